// File: doc/BRIEF.md
# Card Function Configuration Register Block

This block holds the configuration registers of one function on a 16-bit removable card. The registers live in attribute memory at even byte offsets inside a 16-byte window. The window starts at a base address set by a parameter, so that two functions on one card can use different bases, for example 0x200 and 0x300. The host reaches the registers with single-cycle attribute accesses. A write takes effect at the next clock edge. Read data is combinational while the access strobe is high.

The options register at offset 0x00 controls the function. Its configuration index turns function I/O on when the index is non-zero. Its software-reset bit holds the function in reset, and a hard reset does not clear that bit. Its interrupt-mode bit chooses a level interrupt request or a fixed-width pulse on an active-low line. Five more registers are plain 8-bit storage: configuration/status at 0x02, pin replacement at 0x04, socket/copy at 0x06, I/O base 0 at 0x0A and I/O base 1 at 0x0C. The logic behind these five registers is outside this block.

Top module: `cardfn_cfg_regs`

## Requirements
- R1: The block decodes an access only when `acc_addr` lies inside the 16-byte window starting at parameter `BASE_ADDR`. An instance with a different base does not respond to another instance's window.
- R2: The five storage registers hold 8-bit values. A write to offset 0x02, 0x04, 0x06, 0x0A or 0x0C is returned by a later read of the same offset.
- R3: The options register at offset 0x00 reads back as bit 7 = software reset, bit 6 = interrupt mode (1 = level, 0 = pulse) and bits 5..0 = configuration index.
- R4: A read at an odd address, at an unused even offset (0x08, 0x0E) or outside the window returns 0x00. A write to any of these addresses changes no register.
- R5: `func_rst` is high whenever `hard_rst` is high or the software-reset bit is set.
- R6: The software-reset bit keeps its value through a hard reset. Only `por_n` low or a write to offset 0x00 changes it.
- R7: While the function is in reset, the index reads 0, the mode bit reads 1 and the storage registers read 0x00. Writes to the storage registers have no effect during this time.
- R8: A write that clears the software-reset bit leaves the index at 0, even when the write data carries a non-zero index.
- R9: `io_en` is 1 exactly when the index is non-zero. `io_accept` equals `io_req` while `io_en` is 1 and is 0 otherwise.
- R10: In level mode, outside function reset, `irq_n` is the inverse of `irq_src` in the same cycle.
- R11: In pulse mode, a rising edge of `irq_src` drives `irq_n` low for exactly `PULSE_W` clocks, starting at the first clock edge that samples the new high level.
- R12: `irq_n` stays high while `func_rst` is high.
- R13: After `por_n` or `hard_rst`, the options register reads 0x40, that is level mode with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears every register |
| hard_rst | input | 1 | Card hard-reset pin, active high; leaves the software-reset bit alone |
| acc_en | input | 1 | Attribute-memory access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Attribute byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid while `acc_en` is high and `acc_we` is low |
| io_req | input | 1 | Host I/O cycle request |
| io_accept | output | 1 | I/O cycle passed to the function |
| io_en | output | 1 | Function I/O enabled (index non-zero) |
| func_rst | output | 1 | Reset to the function logic |
| irq_src | input | 1 | Interrupt source from the function, active high |
| irq_n | output | 1 | Interrupt request to the host, active low |

## Verification
The assertions assume that `irq_src` and the access signals change only between clock edges. They also assume that `io_en` can change only through a write or a hard reset, so no external path may alter the index. The stimulus drives every input at the falling edge and holds each access for exactly one cycle. It releases `hard_rst` before it performs any access that is expected to change a register.

// File: rtl/cardfn_cfg_pkg.sv
package cardfn_cfg_pkg;
   localparam int DATA_W   = 8;
   localparam int SLOT_CNT = 8;
   localparam int PLAIN_CNT = 5;
   localparam int WIN_BITS = 4;

   typedef enum logic [2:0] {
      SLOT_OPT  = 3'd0,
      SLOT_STAT = 3'd1,
      SLOT_PIN  = 3'd2,
      SLOT_SOCK = 3'd3,
      SLOT_GAP  = 3'd4,
      SLOT_IOB0 = 3'd5,
      SLOT_IOB1 = 3'd6,
      SLOT_RSV  = 3'd7
   } slot_e;

   // slot (offset/2) that holds storage register i
   function automatic int plain_slot(input int i);
      return (i < 3) ? i + 1 : i + 2;
   endfunction

   function automatic bit slot_used(input int s);
      return (s != int'(SLOT_GAP)) && (s != int'(SLOT_RSV));
   endfunction
endpackage

// File: rtl/cardfn_win_decode.sv
module cardfn_win_decode #(
   parameter int          ADDR_W    = 12,
   parameter logic [31:0] BASE_ADDR = 32'h200
) (
   input  logic                                 acc_en,
   input  logic [ADDR_W-1:0]                    acc_addr,
   output logic [cardfn_cfg_pkg::SLOT_CNT-1:0]  slot_sel
);
   import cardfn_cfg_pkg::*;

   localparam int HI_W = ADDR_W - WIN_BITS;
   localparam logic [ADDR_W-1:0] BASE_V = BASE_ADDR[ADDR_W-1:0];

   logic in_win;
   logic even;

   assign in_win = acc_en && (acc_addr[ADDR_W-1:WIN_BITS] == BASE_V[ADDR_W-1:WIN_BITS]);
   assign even   = ~acc_addr[0];

   for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
      if (slot_used(s)) begin : g_used
         assign slot_sel[s] = in_win && even &&
                              (acc_addr[WIN_BITS-1:1] == 3'(s));
      end else begin : g_hole
         assign slot_sel[s] = 1'b0;
      end
   end
endmodule

// File: rtl/cardfn_opt_reg.sv
module cardfn_opt_reg #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hard_rst,
   input  logic             wr,
   input  logic [7:0]       wdata,
   output logic             sreset,
   output logic             lvl_mode,
   output logic [IDX_W-1:0] cfg_idx,
   output logic             func_rst
);
   // software reset: only power-on reset or a write changes it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)  sreset <= 1'b0;
      else if (wr) sreset <= wdata[7];
   end

   assign func_rst = hard_rst | sreset;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         lvl_mode <= 1'b1;
         cfg_idx  <= '0;
      end else if (func_rst || (wr && wdata[7])) begin
         lvl_mode <= 1'b1;
         cfg_idx  <= '0;
      end else if (wr) begin
         lvl_mode <= wdata[6];
         cfg_idx  <= wdata[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/cardfn_plain_bank.sv
module cardfn_plain_bank #(
   parameter int NREG = 5,
   parameter int DW   = 8
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    func_rst,
   input  logic [NREG-1:0]         wr_sel,
   input  logic [DW-1:0]           wdata,
   output logic [NREG-1:0][DW-1:0] q
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)         q[i] <= '0;
         else if (func_rst)  q[i] <= '0;
         else if (wr_sel[i]) q[i] <= wdata;
      end
   end
endmodule

// File: rtl/cardfn_irq_shape.sv
module cardfn_irq_shape #(
   parameter int PULSE_W  = 8,
   parameter bit PULSE_EN = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic func_rst,
   input  logic lvl_mode,
   input  logic irq_src,
   output logic irq_n
);
   localparam int CW = $clog2(PULSE_W + 1);

   if (PULSE_EN) begin : g_pulse
      logic          src_q;
      logic [CW-1:0] cnt;
      logic          edge_hit;

      assign edge_hit = irq_src && !src_q && !lvl_mode && !func_rst;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            src_q <= 1'b0;
            cnt   <= '0;
         end else begin
            src_q <= irq_src;
            if (func_rst || lvl_mode) cnt <= '0;
            else if (edge_hit)        cnt <= CW'(PULSE_W);
            else if (cnt != '0)       cnt <= cnt - 1'b1;
         end
      end

      always_comb begin
         if (func_rst)      irq_n = 1'b1;
         else if (lvl_mode) irq_n = ~irq_src;
         else               irq_n = (cnt == '0);
      end
   end else begin : g_level
      logic unused_sig;
      assign unused_sig = clk ^ por_n ^ lvl_mode;
      assign irq_n = func_rst | ~irq_src | (unused_sig & 1'b0);
   end
endmodule

// File: rtl/cardfn_cfg_regs.sv
module cardfn_cfg_regs #(
   parameter int          ADDR_W    = 12,
   parameter logic [31:0] BASE_ADDR = 32'h200,
   parameter int          IDX_W     = 6,
   parameter int          PULSE_W   = 8,
   parameter bit          PULSE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hard_rst,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic [7:0]        acc_rdata,
   input  logic              io_req,
   output logic              io_accept,
   output logic              io_en,
   output logic              func_rst,
   input  logic              irq_src,
   output logic              irq_n
);
   import cardfn_cfg_pkg::*;

   if (IDX_W + 2 != DATA_W) begin : g_bad_idx
      $error("IDX_W must leave exactly two control bits in the options byte");
   end
   if (BASE_ADDR % (1 << WIN_BITS) != 0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the 16-byte window");
   end
   if (ADDR_W <= WIN_BITS) begin : g_bad_aw
      $error("ADDR_W too small for the register window");
   end
   if (PULSE_W < 1) begin : g_bad_pw
      $error("PULSE_W must be at least one clock");
   end

   logic [SLOT_CNT-1:0]              slot_sel;
   logic                             wr_any;
   logic                             opt_wr;
   logic [PLAIN_CNT-1:0]             plain_wr;
   logic [PLAIN_CNT-1:0][DATA_W-1:0] plain_q;
   logic                             sreset;
   logic                             lvl_mode;
   logic [IDX_W-1:0]                 cfg_idx;

   cardfn_win_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .acc_en   (acc_en),
      .acc_addr (acc_addr),
      .slot_sel (slot_sel)
   );

   assign wr_any = acc_we;
   assign opt_wr = wr_any && slot_sel[SLOT_OPT];

   for (genvar i = 0; i < PLAIN_CNT; i++) begin : g_wsel
      assign plain_wr[i] = wr_any && slot_sel[plain_slot(i)];
   end

   cardfn_opt_reg #(.IDX_W(IDX_W)) u_opt (
      .clk      (clk),
      .por_n    (por_n),
      .hard_rst (hard_rst),
      .wr       (opt_wr),
      .wdata    (acc_wdata),
      .sreset   (sreset),
      .lvl_mode (lvl_mode),
      .cfg_idx  (cfg_idx),
      .func_rst (func_rst)
   );

   cardfn_plain_bank #(.NREG(PLAIN_CNT), .DW(DATA_W)) u_bank (
      .clk      (clk),
      .por_n    (por_n),
      .func_rst (func_rst),
      .wr_sel   (plain_wr),
      .wdata    (acc_wdata),
      .q        (plain_q)
   );

   cardfn_irq_shape #(.PULSE_W(PULSE_W), .PULSE_EN(PULSE_EN)) u_irq (
      .clk      (clk),
      .por_n    (por_n),
      .func_rst (func_rst),
      .lvl_mode (lvl_mode),
      .irq_src  (irq_src),
      .irq_n    (irq_n)
   );

   always_comb begin
      acc_rdata = '0;
      if (!acc_we) begin
         if (slot_sel[SLOT_OPT]) acc_rdata = {sreset, lvl_mode, cfg_idx};
         for (int i = 0; i < PLAIN_CNT; i++) begin
            if (slot_sel[plain_slot(i)]) acc_rdata = plain_q[i];
         end
      end
   end

   assign io_en     = |cfg_idx;
   assign io_accept = io_req & io_en;
endmodule

// File: rtl/cardfn_cfg_chk.sv
module cardfn_cfg_chk (
   input logic clk,
   input logic por_n,
   input logic hard_rst,
   input logic acc_en,
   input logic acc_we,
   input logic odd_addr,
   input logic opt_wr,
   input logic sreset,
   input logic lvl_mode,
   input logic func_rst,
   input logic io_en,
   input logic io_req,
   input logic io_accept,
   input logic irq_src,
   input logic irq_n
);
   // R6
   sreset_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sreset && !opt_wr) |=> sreset);

   // R9
   io_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (io_req && !io_en) |-> !io_accept);

   // R9
   io_en_source_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(io_en) |-> $past(acc_en && acc_we));

   // R4
   odd_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      (acc_en && acc_we && odd_addr && !hard_rst) |=> $stable(io_en));

   // R12
   irq_quiet_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
      func_rst |-> irq_n);

   // R10
   irq_level_chk: assert property (@(posedge clk) disable iff (!por_n)
      (lvl_mode && !func_rst) |-> (irq_n == !irq_src));
endmodule

bind cardfn_cfg_regs cardfn_cfg_chk u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .hard_rst  (hard_rst),
   .acc_en    (acc_en),
   .acc_we    (acc_we),
   .odd_addr  (acc_addr[0]),
   .opt_wr    (opt_wr),
   .sreset    (sreset),
   .lvl_mode  (lvl_mode),
   .func_rst  (func_rst),
   .io_en     (io_en),
   .io_req    (io_req),
   .io_accept (io_accept),
   .irq_src   (irq_src),
   .irq_n     (irq_n)
);

// File: tb/cardfn_cfg_regs_test.sv
`timescale 1ns/1ps
module cardfn_cfg_regs_test;
   localparam int PW = 8;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        hard_rst = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_we = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  acc_rdata, hi_rdata;
   logic        io_req = 1'b0;
   logic        io_accept, io_en, func_rst, irq_n;
   logic        hi_accept, hi_en, hi_rst, hi_irq_n;
   logic        irq_src = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   cardfn_cfg_regs #(.BASE_ADDR(32'h200), .PULSE_W(PW)) uut (
      .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .acc_en(acc_en),
      .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .io_req(io_req), .io_accept(io_accept),
      .io_en(io_en), .func_rst(func_rst), .irq_src(irq_src), .irq_n(irq_n));

   cardfn_cfg_regs #(.BASE_ADDR(32'h300), .PULSE_W(PW)) u_hi (
      .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .acc_en(acc_en),
      .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(hi_rdata), .io_req(io_req), .io_accept(hi_accept),
      .io_en(hi_en), .func_rst(hi_rst), .irq_src(irq_src), .irq_n(hi_irq_n));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data from the scoreboard
   always begin
      @(negedge clk);
      #5;
      if (acc_en && !acc_we && exp_q.size() > 0)
         check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
   end

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic rd_hi(input logic [11:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
      #5 check(tag, hi_rdata, e);
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lows;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk); #2;
      check("R13 io_en after power-up", {7'd0, io_en}, 8'd0);
      check("R5 func_rst after power-up", {7'd0, func_rst}, 8'd0);
      check("R12 irq_n idle", {7'd0, irq_n}, 8'd1);
      rd(12'h200, 8'h40, "R13 options reset value");

      // R2 storage registers
      wr(12'h202, 8'h5A); wr(12'h204, 8'hC3); wr(12'h206, 8'h81);
      wr(12'h20A, 8'h3C); wr(12'h20C, 8'hFF);
      rd(12'h202, 8'h5A, "R2 status reg");
      rd(12'h204, 8'hC3, "R2 pin reg");
      rd(12'h206, 8'h81, "R2 socket reg");
      rd(12'h20A, 8'h3C, "R2 iobase0");
      rd(12'h20C, 8'hFF, "R2 iobase1");

      // R4 holes and odd addresses
      wr(12'h203, 8'h11); wr(12'h208, 8'h22); wr(12'h20E, 8'h33); wr(12'h201, 8'h3F);
      rd(12'h202, 8'h5A, "R4 odd write left status reg");
      rd(12'h200, 8'h40, "R4 odd write left options reg");
      rd(12'h208, 8'h00, "R4 gap 0x08 reads zero");
      rd(12'h20E, 8'h00, "R4 gap 0x0E reads zero");
      rd(12'h203, 8'h00, "R4 odd read zero");

      // R1 base decode
      wr(12'h302, 8'hA5);
      rd(12'h302, 8'h00, "R1 other window invisible");
      rd(12'h202, 8'h5A, "R1 own window untouched");
      rd_hi(12'h302, 8'hA5, "R1 high-base instance storage");
      rd_hi(12'h202, 8'h00, "R1 high-base ignores low window");

      // R3 / R9 configure, pulse mode
      wr(12'h200, 8'h05);
      rd(12'h200, 8'h05, "R3 options readback");
      #2;
      check("R9 io_en set", {7'd0, io_en}, 8'd1);
      io_req = 1'b1; #1;
      check("R9 io_accept passes", {7'd0, io_accept}, 8'd1);
      check("R9 other function blocks io", {7'd0, hi_accept}, 8'd0);
      io_req = 1'b0;

      // R11 pulse
      @(negedge clk); irq_src = 1'b1;
      lows = 0;
      for (int k = 0; k < PW + 4; k++) begin
         @(negedge clk); #2;
         if (!irq_n) lows++;
      end
      check("R11 pulse width", 8'(lows), 8'(PW));
      irq_src = 1'b0;

      // R10 level mode
      wr(12'h200, 8'h45);
      @(negedge clk); irq_src = 1'b1; #2;
      check("R10 level asserted", {7'd0, irq_n}, 8'd0);
      irq_src = 1'b0; #2;
      check("R10 level released", {7'd0, irq_n}, 8'd1);
      irq_src = 1'b1;

      // R5 / R12 / R7 hard reset
      @(negedge clk); hard_rst = 1'b1; #2;
      check("R5 func_rst on hard reset", {7'd0, func_rst}, 8'd1);
      check("R12 irq_n quiet in reset", {7'd0, irq_n}, 8'd1);
      @(negedge clk); #2;
      check("R9 io_en cleared by hard reset", {7'd0, io_en}, 8'd0);
      hard_rst = 1'b0; irq_src = 1'b0;
      rd(12'h200, 8'h40, "R13 options after hard reset");
      rd(12'h20A, 8'h00, "R7 storage cleared by hard reset");

      // R6 / R7 / R8 software reset
      wr(12'h204, 8'h77);
      wr(12'h200, 8'h83);
      #2;
      check("R5 func_rst on software reset", {7'd0, func_rst}, 8'd1);
      rd(12'h200, 8'hC0, "R7 options forced while held");
      rd(12'h204, 8'h00, "R7 storage forced while held");
      wr(12'h202, 8'h55);
      rd(12'h202, 8'h00, "R7 write ignored in reset");
      @(negedge clk); hard_rst = 1'b1;
      @(negedge clk); hard_rst = 1'b0;
      rd(12'h200, 8'hC0, "R6 software reset survives hard reset");
      wr(12'h200, 8'h07);
      rd(12'h200, 8'h40, "R8 release leaves unconfigured");
      #2;
      check("R8 io_en off after release", {7'd0, io_en}, 8'd0);
      check("R5 func_rst released", {7'd0, func_rst}, 8'd0);
      wr(12'h200, 8'h07);
      rd(12'h200, 8'h07, "R3 configure after release");

      @(negedge clk); @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule